// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that finishes one instruction per clock. It fetches from an instruction memory port and uses a separate data memory port for loads and stores. Both memories sit outside the core and return read data combinationally, in the same cycle as the address. The core contains a 32-entry register file with two read ports and one write port, an immediate extender with three modes, an ALU, a purely combinational control decoder and a four-way next-PC selector.

The instruction set is a small fixed-width subset:
- register-register and register-immediate ALU operations
- word loads and stores
- branch if a register is zero, and branch if it is non-zero
- absolute jump, with or without link
- jump through a register, with or without link

There is no delay slot: the instruction that follows a taken transfer is never executed. The register file, the PC and the data memory all update on the rising clock edge.

Top module: `lsc_core`

## Requirements
- R1: While `rst` is high, the PC is loaded with zero and neither memory nor a register is written. After `rst` falls, the first fetch is from address 0.
- R2: Register 0 always reads as zero. A write aimed at register 0 is discarded.
- R3: Opcode 0x00 is a register-register operation whose result goes to rd[15:11], with sources rs[25:21] and rt[20:16]. The func[5:0] codes are add 0x20, sub 0x22, and 0x24, or 0x25, xor 0x26 and signed set-less-than 0x2A. Any other func code, or a non-zero value in bits [10:6], writes no register.
- R4: The register-immediate operations write rt from rs and imm[15:0]:
  - addi 0x08 and slti 0x0A use the sign-extended immediate.
  - andi 0x0C, ori 0x0D and xori 0x0E use the zero-extended immediate.
  - lui 0x0F writes the immediate into the upper half, with the low half zero.
- R5: Load word (0x23) writes rt with the data word at address rs plus the sign-extended immediate. Store word (0x2B) writes rt to that address and writes no register.
- R6: Branch-if-zero (0x04) and branch-if-non-zero (0x05) test rs. When the branch is taken, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. When it is not taken, the next PC is PC+4. A branch writes no register.
- R7: Jump (0x02) and jump-and-link (0x03) go to PC[31:28] joined with target[25:0] shifted left by 2. Jump-and-link also writes PC+4 into register 31.
- R8: Register jump (0x12) and register jump-and-link (0x13) go to the value of rs. Register jump-and-link also writes PC+4 into register 31.
- R9: The instruction that follows a taken branch or jump is not executed.
- R10: An opcode outside the subset writes nothing and advances the PC by 4.
- R11: Every instruction that does not transfer control advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction fetch address (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, taken at the rising edge |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, combinational |

## Verification
A wrong next-PC choice shows up on `imem_addr` in the very next cycle. A corrupted register value stays hidden until an instruction stores it, so every program ends by storing each register it computed. The stored words, checked against arithmetic expectations, expose any wrong ALU, extender or write-back result within a few cycles of the instruction that produced it. A skipped-instruction marker register shows whether an instruction after a taken transfer ran. A final store of that marker exposes the fault at the end of each program.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_JAL   = 6'h03;
  localparam logic [5:0] OP_BEQZ  = 6'h04;
  localparam logic [5:0] OP_BNEZ  = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_SLTI  = 6'h0A;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_XORI  = 6'h0E;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_JR    = 6'h12;
  localparam logic [5:0] OP_JALR  = 6'h13;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {PC_SEQ, PC_BR, PC_IND, PC_ABS} pc_sel_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;
  typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dst_sel_e;
  typedef enum logic [1:0] {EXT_SX, EXT_ZX, EXT_HI} ext_e;
  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT, ALU_B} alu_op_e;

  typedef struct packed {
    pc_sel_e  pc_sel;
    wb_sel_e  wb_sel;
    dst_sel_e dst_sel;
    ext_e     ext;
    alu_op_e  alu_op;
    logic     b_imm;
    logic     rf_we;
    logic     mem_we;
  } ctrl_t;
endpackage

// File: rtl/lsc_regfile.sv
module lsc_regfile #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra1,
  output logic [DW-1:0] rd1,
  input  logic [AW-1:0] ra2,
  output logic [DW-1:0] rd2
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) mem[waddr] <= wdata;
  end

  // R2: entry 0 is never stored, its read is forced to zero
  assign rd1 = (ra1 == '0) ? '0 : mem[ra1];
  assign rd2 = (ra2 == '0) ? '0 : mem[ra2];
endmodule

// File: rtl/lsc_imm_ext.sv
module lsc_imm_ext
  import lsc_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  logic [IW-1:0] imm,
  input  ext_e          mode,
  output logic [DW-1:0] ext
);
  localparam int PADW = DW - IW;

  always_comb begin
    unique case (mode)
      EXT_ZX:  ext = {{PADW{1'b0}}, imm};
      EXT_HI:  ext = {imm, {PADW{1'b0}}};
      default: ext = {{PADW{imm[IW-1]}}, imm};
    endcase
  end
endmodule

// File: rtl/lsc_alu.sv
module lsc_alu
  import lsc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_e       op,
  output logic [DW-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SLT: y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_B:   y = b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/lsc_ctrl_dec.sv
module lsc_ctrl_dec
  import lsc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] func,
  input  logic       shamt_zero,
  input  logic       rs_is_zero,
  output ctrl_t      ctl
);
  always_comb begin
    ctl.pc_sel  = PC_SEQ;
    ctl.wb_sel  = WB_ALU;
    ctl.dst_sel = DST_RT;
    ctl.ext     = EXT_SX;
    ctl.alu_op  = ALU_ADD;
    ctl.b_imm   = 1'b0;
    ctl.rf_we   = 1'b0;
    ctl.mem_we  = 1'b0;
    unique case (op)
      OP_RTYPE: begin
        ctl.dst_sel = DST_RD;
        ctl.rf_we   = shamt_zero;
        unique case (func)
          FN_ADD:  ctl.alu_op = ALU_ADD;
          FN_SUB:  ctl.alu_op = ALU_SUB;
          FN_AND:  ctl.alu_op = ALU_AND;
          FN_OR:   ctl.alu_op = ALU_OR;
          FN_XOR:  ctl.alu_op = ALU_XOR;
          FN_SLT:  ctl.alu_op = ALU_SLT;
          default: ctl.rf_we  = 1'b0;
        endcase
      end
      OP_ADDI: begin ctl.b_imm = 1'b1; ctl.rf_we = 1'b1; end
      OP_SLTI: begin ctl.b_imm = 1'b1; ctl.rf_we = 1'b1; ctl.alu_op = ALU_SLT; end
      OP_ANDI: begin ctl.b_imm = 1'b1; ctl.rf_we = 1'b1; ctl.alu_op = ALU_AND; ctl.ext = EXT_ZX; end
      OP_ORI:  begin ctl.b_imm = 1'b1; ctl.rf_we = 1'b1; ctl.alu_op = ALU_OR;  ctl.ext = EXT_ZX; end
      OP_XORI: begin ctl.b_imm = 1'b1; ctl.rf_we = 1'b1; ctl.alu_op = ALU_XOR; ctl.ext = EXT_ZX; end
      OP_LUI:  begin ctl.b_imm = 1'b1; ctl.rf_we = 1'b1; ctl.alu_op = ALU_B;   ctl.ext = EXT_HI; end
      OP_LW:   begin ctl.b_imm = 1'b1; ctl.rf_we = 1'b1; ctl.wb_sel = WB_MEM; end
      OP_SW:   begin ctl.b_imm = 1'b1; ctl.mem_we = 1'b1; end
      OP_BEQZ: ctl.pc_sel = rs_is_zero ? PC_BR : PC_SEQ;
      OP_BNEZ: ctl.pc_sel = rs_is_zero ? PC_SEQ : PC_BR;
      OP_J:    ctl.pc_sel = PC_ABS;
      OP_JAL: begin
        ctl.pc_sel = PC_ABS; ctl.wb_sel = WB_LINK; ctl.dst_sel = DST_LINK; ctl.rf_we = 1'b1;
      end
      OP_JR:   ctl.pc_sel = PC_IND;
      OP_JALR: begin
        ctl.pc_sel = PC_IND; ctl.wb_sel = WB_LINK; ctl.dst_sel = DST_LINK; ctl.rf_we = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lsc_core.sv
module lsc_core
  import lsc_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] imem_addr,
  input  logic [DW-1:0] imem_rdata,
  output logic [DW-1:0] dmem_addr,
  output logic [DW-1:0] dmem_wdata,
  output logic          dmem_we,
  input  logic [DW-1:0] dmem_rdata
);
  localparam logic [AW-1:0] LINK_REG = AW'((2 ** AW) - 1);
  localparam logic [DW-1:0] STEP     = DW'(4);

  logic [DW-1:0] pc, pc4, pc_nxt, br_tgt, abs_tgt;
  logic [DW-1:0] rs_val, rt_val, imm, alu_b, alu_y, wb_val;
  logic [AW-1:0] rf_waddr;
  logic          rf_we;
  logic [31:0]   instr;
  ctrl_t         ctl;

  assign instr = imem_rdata;
  assign pc4   = pc + STEP;

  lsc_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(wb_val),
    .ra1(instr[25:21]), .rd1(rs_val), .ra2(instr[20:16]), .rd2(rt_val)
  );

  lsc_ctrl_dec u_dec (
    .op(instr[31:26]), .func(instr[5:0]), .shamt_zero(instr[10:6] == 5'd0),
    .rs_is_zero(rs_val == '0), .ctl(ctl)
  );

  lsc_imm_ext #(.DW(DW), .IW(16)) u_ext (.imm(instr[15:0]), .mode(ctl.ext), .ext(imm));

  assign alu_b = ctl.b_imm ? imm : rt_val;

  lsc_alu #(.DW(DW)) u_alu (.a(rs_val), .b(alu_b), .op(ctl.alu_op), .y(alu_y));

  assign br_tgt  = pc4 + {imm[DW-3:0], 2'b00};
  assign abs_tgt = {pc[DW-1:DW-4], instr[25:0], 2'b00};

  always_comb begin
    unique case (ctl.pc_sel)
      PC_BR:   pc_nxt = br_tgt;
      PC_IND:  pc_nxt = rs_val;
      PC_ABS:  pc_nxt = abs_tgt;
      default: pc_nxt = pc4;
    endcase
    unique case (ctl.wb_sel)
      WB_MEM:  wb_val = dmem_rdata;
      WB_LINK: wb_val = pc4;
      default: wb_val = alu_y;
    endcase
    unique case (ctl.dst_sel)
      DST_RD:   rf_waddr = instr[15:11];
      DST_LINK: rf_waddr = LINK_REG;
      default:  rf_waddr = instr[20:16];
    endcase
  end

  assign rf_we = ctl.rf_we & ~rst;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_nxt;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctl.mem_we & ~rst;

  logic is_branch;
  assign is_branch = (instr[31:26] == OP_BEQZ) || (instr[31:26] == OP_BNEZ);

  AST_RESET_PC: assert property (@(posedge clk) rst |=> (pc == '0)); // R1
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (ctl.pc_sel == PC_SEQ) |=> (pc == $past(pc) + STEP)); // R11
  AST_STORE_NO_REG: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !rf_we); // R5
  AST_LINK_DEST: assert property (@(posedge clk) disable iff (rst)
    (rf_we && ctl.wb_sel == WB_LINK) |-> (rf_waddr == LINK_REG)); // R7
  AST_BRANCH_QUIET: assert property (@(posedge clk) disable iff (rst)
    is_branch |-> (!rf_we && !dmem_we)); // R6
endmodule

// File: tb/test_lsc_core.sv
module test_lsc_core;
  localparam logic [5:0] O_R = 6'h00, O_J = 6'h02, O_JAL = 6'h03, O_BEQZ = 6'h04, O_BNEZ = 6'h05;
  localparam logic [5:0] O_ADDI = 6'h08, O_SLTI = 6'h0A, O_ANDI = 6'h0C, O_ORI = 6'h0D;
  localparam logic [5:0] O_XORI = 6'h0E, O_LUI = 6'h0F, O_JR = 6'h12, O_JALR = 6'h13;
  localparam logic [5:0] O_LW = 6'h23, O_SW = 6'h2B;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic dmem_we;
  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 64; i++) dmem[i] <= 32'h0;
    end else if (dmem_we) begin
      dmem[dmem_addr[7:2]] <= dmem_wdata;
    end
  end

  lsc_core i_lsc_core (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
    return {O_R, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] im);
    return {op, rs, rt, im};
  endfunction
  function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] t);
    return {op, t};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_imem();
    for (int i = 0; i < 64; i++) imem[i] = enc_i(O_BEQZ, 5'd0, 5'd0, 16'hFFFF);
  endtask

  task automatic run(int cycles, bit check_reset);
    @(negedge clk);
    rst = 1'b1;
    clr = 1'b1;
    repeat (2) @(negedge clk);
    clr = 1'b0;
    if (check_reset) begin
      chk("R1 reset pc", imem_addr, 32'h0);
      chk("R1 no store in reset", {31'h0, dmem_we}, 32'h0);
    end
    rst = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic alu_case(logic [31:0] a, logic [31:0] b, bit first);
    logic [31:0] sx, zx;
    sx = {{16{b[15]}}, b[15:0]};
    zx = {16'h0, b[15:0]};
    clear_imem();
    imem[0]  = enc_i(O_LUI, 5'd0, 5'd1, a[31:16]);
    imem[1]  = enc_i(O_ORI, 5'd1, 5'd1, a[15:0]);
    imem[2]  = enc_i(O_LUI, 5'd0, 5'd2, b[31:16]);
    imem[3]  = enc_i(O_ORI, 5'd2, 5'd2, b[15:0]);
    imem[4]  = enc_r(6'h20, 5'd1, 5'd2, 5'd3);
    imem[5]  = enc_r(6'h22, 5'd1, 5'd2, 5'd4);
    imem[6]  = enc_r(6'h24, 5'd1, 5'd2, 5'd5);
    imem[7]  = enc_r(6'h25, 5'd1, 5'd2, 5'd6);
    imem[8]  = enc_r(6'h26, 5'd1, 5'd2, 5'd7);
    imem[9]  = enc_r(6'h2A, 5'd1, 5'd2, 5'd8);
    imem[10] = enc_i(O_ADDI, 5'd1, 5'd9, b[15:0]);
    imem[11] = enc_i(O_SLTI, 5'd1, 5'd10, b[15:0]);
    imem[12] = enc_i(O_ANDI, 5'd1, 5'd11, b[15:0]);
    imem[13] = enc_i(O_ORI, 5'd1, 5'd12, b[15:0]);
    imem[14] = enc_i(O_XORI, 5'd1, 5'd13, b[15:0]);
    imem[15] = enc_i(O_LUI, 5'd0, 5'd14, b[15:0]);
    imem[16] = enc_i(O_ADDI, 5'd0, 5'd15, 16'h0055);
    imem[17] = enc_r(6'h3F, 5'd1, 5'd2, 5'd15);
    imem[18] = enc_r(6'h20, 5'd1, 5'd2, 5'd0);
    for (int k = 0; k < 13; k++) imem[19 + k] = enc_i(O_SW, 5'd0, 5'(3 + k), 16'(4 * k));
    imem[32] = enc_i(O_SW, 5'd0, 5'd0, 16'd52);
    run(40, first);
    chk("R3 add", dmem[0], a + b);
    chk("R3 sub", dmem[1], a - b);
    chk("R3 and", dmem[2], a & b);
    chk("R3 or", dmem[3], a | b);
    chk("R3 xor", dmem[4], a ^ b);
    chk("R3 slt", dmem[5], {31'h0, $signed(a) < $signed(b)});
    chk("R4 addi", dmem[6], a + sx);
    chk("R4 slti", dmem[7], {31'h0, $signed(a) < $signed(sx)});
    chk("R4 andi", dmem[8], a & zx);
    chk("R4 ori", dmem[9], a | zx);
    chk("R4 xori", dmem[10], a ^ zx);
    chk("R4 lui", dmem[11], {b[15:0], 16'h0});
    chk("R3 unknown func no write", dmem[12], 32'h55);
    chk("R2 r0 stays zero", dmem[13], 32'h0);
    chk("R6 halt loop pc", imem_addr, 32'd132);
  endtask

  initial begin
    logic [31:0] va [8];
    logic [31:0] vb [8];
    va = '{32'd5, 32'd3, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 32'h1234ABCD, 32'h0, 32'hDEADBEEF};
    vb = '{32'd3, 32'd5, 32'd1, 32'd1, 32'h7FFFFFFF, 32'h0000F00F, 32'h0, 32'hFFFF8001};
    for (int t = 0; t < 8; t++) alu_case(va[t], vb[t], t == 0);

    clear_imem();
    imem[0]  = enc_i(O_ADDI, 5'd0, 5'd1, 16'd100);
    imem[1]  = enc_i(O_SW, 5'd0, 5'd1, 16'd8);
    imem[2]  = enc_i(O_LW, 5'd0, 5'd2, 16'd8);
    imem[3]  = enc_i(O_ADDI, 5'd0, 5'd4, 16'd16);
    imem[4]  = enc_i(O_LW, 5'd4, 5'd5, 16'hFFF8);
    imem[5]  = enc_i(O_ADDI, 5'd5, 5'd5, 16'd7);
    imem[6]  = enc_i(O_SW, 5'd4, 5'd5, 16'd4);
    imem[7]  = enc_i(O_ADDI, 5'd0, 5'd6, 16'd0);
    imem[8]  = enc_i(O_BEQZ, 5'd0, 5'd0, 16'd1);
    imem[9]  = enc_i(O_ADDI, 5'd6, 5'd6, 16'd1);
    imem[10] = enc_i(O_BNEZ, 5'd0, 5'd0, 16'd1);
    imem[11] = enc_i(O_ADDI, 5'd6, 5'd6, 16'd2);
    imem[12] = enc_i(O_BNEZ, 5'd1, 5'd0, 16'd1);
    imem[13] = enc_i(O_ADDI, 5'd6, 5'd6, 16'd4);
    imem[14] = enc_i(O_BEQZ, 5'd1, 5'd0, 16'd1);
    imem[15] = enc_i(O_ADDI, 5'd6, 5'd6, 16'd8);
    imem[16] = enc_i(O_SW, 5'd0, 5'd6, 16'd12);
    imem[17] = enc_j(O_JAL, 26'd20);
    imem[18] = enc_i(O_ADDI, 5'd6, 5'd6, 16'd16);
    imem[19] = enc_i(O_ADDI, 5'd6, 5'd6, 16'd16);
    imem[20] = enc_i(O_SW, 5'd0, 5'd31, 16'd16);
    imem[21] = enc_i(O_ADDI, 5'd0, 5'd7, 16'd108);
    imem[22] = enc_i(O_JALR, 5'd7, 5'd0, 16'd0);
    for (int k = 23; k < 27; k++) imem[k] = enc_i(O_ADDI, 5'd6, 5'd6, 16'd32);
    imem[27] = enc_i(O_SW, 5'd0, 5'd31, 16'd24);
    imem[28] = enc_i(O_ADDI, 5'd0, 5'd8, 16'd124);
    imem[29] = enc_i(O_JR, 5'd8, 5'd0, 16'd0);
    imem[30] = enc_i(O_ADDI, 5'd6, 5'd6, 16'd64);
    imem[31] = enc_j(O_J, 26'd33);
    imem[32] = enc_i(O_ADDI, 5'd6, 5'd6, 16'd128);
    imem[33] = enc_i(O_SW, 5'd0, 5'd6, 16'd28);
    imem[34] = {6'h3F, 5'd0, 5'd6, 16'h1234};
    imem[35] = enc_i(O_SW, 5'd0, 5'd6, 16'd32);
    run(45, 1'b1);
    chk("R5 store word", dmem[2], 32'd100);
    chk("R5 load negative offset then store", dmem[5], 32'd107);
    chk("R6 branch taken/not-taken mix", dmem[3], 32'd10);
    chk("R7 jal links pc+4", dmem[4], 32'd72);
    chk("R8 jalr links pc+4", dmem[6], 32'd92);
    chk("R9 no delay slot after jumps", dmem[7], 32'd10);
    chk("R10 unknown opcode writes nothing", dmem[8], 32'd10);
    chk("R11 pc reaches halt at 144", imem_addr, 32'd144);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule